// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped cache and keeps the lines that cache throws away. When the main cache misses, its controller presents the missing block address on the lookup port. The buffer compares that address against every stored entry in the same cycle and returns a hit flag and the full line. On a hit the controller refills the main cache from the buffer rather than from lower memory. The line that the refill pushes out of the main cache is handed over on the eviction port and takes the place of the entry that hit, so the two lines are exchanged.

When the lookup misses, the evicted line goes into the slot that was filled longest ago, in first-in first-out order. An evicted line may also be offered with no lookup in the same cycle. If the lookup address equals the address of the line being evicted in that cycle, the evicted line is forwarded straight back. Two saturating counters record how many lookups hit and how many missed. The main cache arrays and the memory refill path lie outside this block.

Top module: `victim_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and both counters read zero, so any lookup misses.
- R2: In the cycle `lk_valid` is high, `hit_o` and `hit_data_o` reflect the lookup combinationally. The line is returned as stored, with word 0 in bits 31:0 and word 3 in bits 127:96.
- R3: On a stored-entry hit with `ev_valid` high, that entry takes the evicted address and line at the clock edge. The hit address then misses and the evicted address hits.
- R4: On a lookup miss, or with no lookup, a valid eviction is written into the entry filled least recently. After four insertions, a fifth one overwrites the first.
- R5: A stored-entry hit does not move the FIFO replacement position.
- R6: When `lk_valid`, `ev_valid` and `lk_addr == ev_addr` are all true in one cycle, `hit_o` is 1, `hit_data_o` equals `ev_data`, and the line is not stored.
- R7: A match needs equality on all 26 block-address bits. Addresses that differ only in bit 25 or only in bit 0 miss.
- R8: `hit_count` rises by one for each lookup that hits and `miss_count` rises by one for each lookup that misses. Each counter holds at its all-ones value.
- R9: With `lk_valid` low, `hit_o` is 0 whatever the address, and neither counter changes.
- R10: A stored-entry hit with `ev_valid` low invalidates the matched entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request after a main-cache miss |
| lk_addr | input | 26 | Block address looked up |
| ev_valid | input | 1 | A line is being evicted from the main cache |
| ev_addr | input | 26 | Block address of the evicted line |
| ev_data | input | 128 | Evicted line, four 32-bit words |
| hit_o | output | 1 | Lookup found the line |
| hit_data_o | output | 128 | Line returned on a hit |
| hit_count | output | CNT_W | Saturating count of lookup hits |
| miss_count | output | CNT_W | Saturating count of lookup misses |

## Verification
The bench fills all four slots and then adds a fifth line. A buffer that replaced in any order other than oldest-first would keep the wrong line and miss on a survivor. It swaps and invalidates entries by hitting them, then inserts two more lines. A design that advanced the replacement position on hits would overwrite a different slot than expected. Lookups equal to the same-cycle eviction catch a design that returns stale or no data, or that stores the forwarded line. Addresses one bit off at each end of the tag expose a partial compare. A long run of misses with narrow counters shows whether a counter wraps instead of holding.

// File: rtl/vc_pkg.sv
// Package: shared widths and the stored entry type of the victim line buffer.
// Assumes lines of VC_WORDS words of VC_WORD_W bits, tagged by a block address.
package vc_pkg;
    localparam int unsigned VC_ADDR_W = 26;
    localparam int unsigned VC_WORD_W = 32;
    localparam int unsigned VC_WORDS  = 4;
    localparam int unsigned VC_LINE_W = VC_WORD_W * VC_WORDS;

    typedef logic [VC_ADDR_W-1:0] vc_addr_t;
    typedef logic [VC_LINE_W-1:0] vc_line_t;

    typedef struct packed {
        logic     valid;
        vc_addr_t addr;
        vc_line_t line;
    } vc_entry_t;
endpackage

// File: rtl/vc_match.sv
// Module: vc_match
// Compares one block address against all entries in parallel and selects the
// matching line. Assumes at most one valid entry carries any given address.
module vc_match
    import vc_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  vc_entry_t [ENTRIES-1:0] entries,
    input  vc_addr_t                key,
    output logic [ENTRIES-1:0]      match_vec,
    output logic                    any_match,
    output logic [IDX_W-1:0]        match_idx,
    output vc_line_t                match_line
);
    // One comparator per entry: valid bit and the full address tag.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = entries[g].valid && (entries[g].addr == key);
    end

    assign any_match = |match_vec;

    // Encode the matching slot and mux out its line.
    always_comb begin
        match_idx  = '0;
        match_line = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                match_idx  = IDX_W'(i);
                match_line = entries[i].line;
            end
        end
    end

    // R2: the stored lines never hold two valid copies of one address.
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
endmodule

// File: rtl/vc_fifo_ptr.sv
// Module: vc_fifo_ptr
// Points at the slot filled least recently and steps past it on each insertion.
// Assumes the caller asserts adv only when it writes the pointed slot.
module vc_fifo_ptr #(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_q;

    // Step the replacement position, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    // R5: without an insertion the replacement position stays put.
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));
endmodule

// File: rtl/vc_sat_counter.sv
// Module: vc_sat_counter
// Event counter that climbs by one per pulse and holds at its all-ones value.
module vc_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    // Count events until the top value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R8: a full counter stays full.
    a_r8_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1));
    // R8: a pulse below the top moves the count by exactly one.
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/victim_cache.sv
// Module: victim_cache
// Fully associative store for lines evicted from a direct-mapped cache.
// Lookup is combinational. A hit swaps in the evicted line, or frees the slot
// when no line is evicted. A miss inserts the evicted line first-in first-out.
// Assumes the controller never offers an eviction whose address is already stored.
module victim_cache
    import vc_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VC_ADDR_W-1:0] lk_addr,
    input  logic                 ev_valid,
    input  logic [VC_ADDR_W-1:0] ev_addr,
    input  logic [VC_LINE_W-1:0] ev_data,
    output logic                 hit_o,
    output logic [VC_LINE_W-1:0] hit_data_o,
    output logic [CNT_W-1:0]     hit_count,
    output logic [CNT_W-1:0]     miss_count
);
    vc_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]      match_vec;
    logic                    any_match;
    logic [IDX_W-1:0]        match_idx;
    vc_line_t                match_line;
    logic [IDX_W-1:0]        wr_ptr;
    logic                    bypass;
    logic                    store_hit;
    logic                    do_insert;
    logic                    miss_evt;

    vc_match #(.ENTRIES(ENTRIES)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .entries    (ent_q),
        .key        (lk_addr),
        .match_vec  (match_vec),
        .any_match  (any_match),
        .match_idx  (match_idx),
        .match_line (match_line)
    );

    // Classify the cycle: forward, stored hit, or FIFO insertion.
    always_comb begin
        bypass    = lk_valid && ev_valid && (ev_addr == lk_addr);
        store_hit = lk_valid && any_match && !bypass;
        do_insert = ev_valid && !bypass && !store_hit;
        miss_evt  = lk_valid && !bypass && !any_match;
    end

    assign hit_o      = bypass || store_hit;
    assign hit_data_o = bypass ? ev_data : (store_hit ? match_line : '0);

    vc_fifo_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (do_insert),
        .ptr   (wr_ptr)
    );

    // Update the stored lines: swap or free on a hit, fill the oldest slot on insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i].valid <= 1'b0;
                ent_q[i].addr  <= '0;
                ent_q[i].line  <= '0;
            end
        end else if (store_hit) begin
            ent_q[match_idx].valid <= ev_valid;
            if (ev_valid) begin
                ent_q[match_idx].addr <= ev_addr;
                ent_q[match_idx].line <= ev_data;
            end
        end else if (do_insert) begin
            ent_q[wr_ptr].valid <= 1'b1;
            ent_q[wr_ptr].addr  <= ev_addr;
            ent_q[wr_ptr].line  <= ev_data;
        end
    end

    vc_sat_counter #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit_o),
        .cnt   (hit_count)
    );

    vc_sat_counter #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_evt),
        .cnt   (miss_count)
    );

    // R1: reset leaves every slot empty.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (match_vec == '0));
    // R6: a same-cycle eviction of the looked-up address is forwarded.
    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ev_valid && lk_addr == ev_addr) |-> (hit_o && hit_data_o == ev_data));
    // R9: no lookup, no hit.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !hit_o);
    // R5: a stored-entry hit leaves the replacement position unchanged.
    a_r5_hit_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        store_hit |=> (wr_ptr == $past(wr_ptr)));
    // R10: a hit with no eviction leaves no valid copy of that address.
    a_r10_free_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ev_valid && any_match) |=> !$past(lk_valid) || !any_match || ($past(lk_addr) != lk_addr));
endmodule

// File: tb/victim_cache_bench.sv
// Directed bench for victim_cache: one task per scenario, each checks its own results.
module victim_cache_bench;
    localparam int CW  = 6;
    localparam int MAX = (1 << CW) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [25:0]  lk_addr = '0;
    logic         ev_valid = 1'b0;
    logic [25:0]  ev_addr = '0;
    logic [127:0] ev_data = '0;
    logic         hit_o;
    logic [127:0] hit_data_o;
    logic [CW-1:0] hit_count;
    logic [CW-1:0] miss_count;

    int total = 0;
    int bad = 0;
    int exp_h = 0;
    int exp_m = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    victim_cache #(.ENTRIES(4), .CNT_W(CW)) u_victim_cache (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_addr (lk_addr),
        .ev_valid (ev_valid), .ev_addr (ev_addr), .ev_data (ev_data),
        .hit_o (hit_o), .hit_data_o (hit_data_o),
        .hit_count (hit_count), .miss_count (miss_count)
    );

    function automatic logic [127:0] mk(input logic [25:0] a, input logic [31:0] salt);
        return {salt, 6'd0, a, ~{6'd0, a}, salt ^ 32'h5A5A_5A5A};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational response, pass the rising edge.
    task automatic cyc(input bit lk, input logic [25:0] la, input bit ev, input logic [25:0] ea,
                       input logic [127:0] ed, input bit exp_hit, input logic [127:0] exp_d,
                       input string req);
        @(negedge clk);
        lk_valid = lk; lk_addr = la; ev_valid = ev; ev_addr = ea; ev_data = ed;
        #1;
        chk(req, {127'd0, hit_o}, {127'd0, exp_hit});
        if (exp_hit) chk(req, hit_data_o, exp_d);
        if (lk) begin
            if (exp_hit) begin if (exp_h < MAX) exp_h++; end
            else begin if (exp_m < MAX) exp_m++; end
        end
        @(posedge clk); #1;
        lk_valid = 1'b0; ev_valid = 1'b0;
    endtask

    task automatic look(input logic [25:0] a, input bit exp_hit, input logic [127:0] exp_d, input string req);
        cyc(1'b1, a, 1'b0, '0, '0, exp_hit, exp_d, req);
    endtask

    task automatic put(input logic [25:0] a, input logic [31:0] s);
        cyc(1'b0, a, 1'b1, a, mk(a, s), 1'b0, '0, "R9");
    endtask

    task automatic counts(input string req);
        chk({req, " hits"}, 128'(hit_count), 128'(exp_h));
        chk({req, " misses"}, 128'(miss_count), 128'(exp_m));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lk_valid = 0; ev_valid = 0;
        @(posedge clk); @(posedge clk); #1; rst_n = 1'b1;
        exp_h = 0; exp_m = 0;
    endtask

    // R1: empty after reset, counters at zero.
    task automatic t_reset();
        do_reset();
        counts("R1");
        look(26'h5, 1'b0, '0, "R1");
        counts("R1");
    endtask

    // R4/R3/R10/R5: fill, overflow, swap, free, then insert again.
    task automatic t_fifo_swap();
        do_reset();
        for (int i = 0; i < 5; i++) put(26'h100 + 26'(i), 32'hA0 + i);
        counts("R9");
        look(26'h100, 1'b0, '0, "R4");
        cyc(1'b1, 26'h101, 1'b1, 26'h201, mk(26'h201, 32'hB1), 1'b1, mk(26'h101, 32'hA1), "R3");
        look(26'h101, 1'b0, '0, "R3");
        look(26'h201, 1'b1, mk(26'h201, 32'hB1), "R3");
        look(26'h201, 1'b0, '0, "R10");
        put(26'h300, 32'hC0);
        put(26'h301, 32'hC1);
        look(26'h103, 1'b1, mk(26'h103, 32'hA3), "R5");
        look(26'h102, 1'b0, '0, "R5");
        look(26'h104, 1'b1, mk(26'h104, 32'hA4), "R4");
        look(26'h300, 1'b1, mk(26'h300, 32'hC0), "R5");
        look(26'h301, 1'b1, mk(26'h301, 32'hC1), "R5");
        cyc(1'b1, 26'h400, 1'b1, 26'h401, mk(26'h401, 32'hD1), 1'b0, '0, "R4");
        look(26'h401, 1'b1, mk(26'h401, 32'hD1), "R4");
        counts("R8");
    endtask

    // R6: same-cycle forward, not stored.
    task automatic t_forward();
        do_reset();
        cyc(1'b1, 26'h777, 1'b1, 26'h777, mk(26'h777, 32'hEE), 1'b1, mk(26'h777, 32'hEE), "R6");
        look(26'h777, 1'b0, '0, "R6");
        counts("R6");
    endtask

    // R7: full-width tag compare.
    task automatic t_tag();
        do_reset();
        put(26'h0000123, 32'h77);
        look(26'h2000123, 1'b0, '0, "R7");
        look(26'h0000122, 1'b0, '0, "R7");
        look(26'h0000123, 1'b1, mk(26'h0000123, 32'h77), "R7");
    endtask

    // R9: no lookup means no hit and no count.
    task automatic t_idle();
        do_reset();
        put(26'h55, 32'h1);
        @(negedge clk); lk_valid = 1'b0; lk_addr = 26'h55; #1;
        chk("R9", {127'd0, hit_o}, 128'd0);
        @(posedge clk); #1;
        counts("R9");
        look(26'h55, 1'b1, mk(26'h55, 32'h1), "R9");
    endtask

    // R8: misses saturate.
    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < MAX + 6; i++) look(26'h3000 + 26'(i), 1'b0, '0, "R8");
        counts("R8");
        chk("R8 top", 128'(miss_count), 128'(MAX));
    endtask

    initial begin
        t_reset();
        t_fifo_swap();
        t_forward();
        t_tag();
        t_idle();
        t_saturate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule